// File: doc/BRIEF.md
# Glitch-Free Dual Clock Source Switch

This block picks one of two unrelated input clocks, a crystal reference clock and a faster VCO clock, and derives from it a base clock and a bus clock. When the select input changes, a handover controller shuts off the outgoing clock and only then turns on the incoming one. Each step waits for the clock it affects to be low, so the switched clock never carries a shortened pulse. While the handover runs, the switched clock stays low and the derived clocks hold their levels.

The switched clock drives a divide-by-two stage, which gives the base clock a 50% duty cycle. A second divide-by-two stage forms the bus clock, which therefore runs at a quarter of the chosen source. A busy flag marks the interval between a select change and the moment the new source takes over. After reset the reference clock is in use, and the VCO clock may stay stopped for as long as it is not selected.

Top module: `clksw_top`

## Requirements
- R1: With `sel`=0 the outputs are derived from `clk_ref`; with `sel`=1 they are derived from `clk_vco`. The base clock period is twice the period of the chosen source.
- R2: The base clock has a 50% duty cycle. Its high time and its low time each equal one period of the chosen source.
- R3: The bus clock changes only on rising edges of the base clock. Its period is four periods of the chosen source.
- R4: No level of the base clock lasts less than one period of the faster source. A clock enable changes only while its own clock is low.
- R5: The two source enables are never active at the same time. The old source is disabled before the new one is enabled.
- R6: A handover finishes within three reference periods plus three VCO periods, measured from the change of `sel`.
- R7: `busy` is 1 from the change of `sel` until the new source drives the output. It is 0 once the handover is complete.
- R8: While `rst_n` is 0, `base_clk` and `bus_clk` are 0 and `busy` is 1. After reset the reference clock is selected and runs the outputs even if `clk_vco` is not toggling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference (crystal) clock |
| clk_vco | input | 1 | VCO clock, asynchronous to clk_ref |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Source select: 0 = reference, 1 = VCO |
| base_clk | output | 1 | Base clock, chosen source divided by two |
| bus_clk | output | 1 | Bus clock, base clock divided by two |
| busy | output | 1 | Handover in progress |

## Verification
The bench builds the block with its default parameters: two synchronizer stages per enable and reset path, and two divider stages. These defaults make the three-cycle handover bound and the divide-by-four bus rate checkable. The reference clock runs at 10 ns and the VCO clock at 7 ns, and the two are not related. With these rates the bench can measure periods and duty cycle on either source, check the handover time against the combined bound in both directions, and spot any base clock level shorter than one VCO period. The first part of the run keeps the VCO clock stopped, to show that the reference path works without it.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  typedef enum logic {SRC_REF = 1'b0, SRC_VCO = 1'b1} src_e;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned DIV_STAGES_DEF  = 2;
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
  parameter int unsigned STAGES   = 2,
  parameter bit          FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned MSB = STAGES - 1;

  logic [MSB:0] sr_q;
  logic [MSB:0] sr_nxt;

  always_comb begin
    sr_nxt = {sr_q[MSB-1:0], d};
  end

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_nxt;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_nxt;
      end
    end
  endgenerate

  assign q = sr_q[MSB];
endmodule

// File: rtl/clksw_leg.sv
`timescale 1ns/1ps
module clksw_leg #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic en,
  output logic rst_sync_n,
  output logic clk_gated
);
  clksw_sync #(.STAGES(STAGES), .FALL_EDGE(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  clksw_sync #(.STAGES(STAGES), .FALL_EDGE(1'b1)) u_en_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (req),
    .q     (en)
  );

  assign clk_gated = clk & en;
endmodule

// File: rtl/clksw_div.sv
`timescale 1ns/1ps
module clksw_div #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_in,
  input  logic              rst_n,
  output logic [STAGES-1:0] taps
);
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic ck;
      logic t_q;
      logic t_nxt;
      if (i == 0) begin : g_first
        assign ck = clk_in;
      end else begin : g_next
        assign ck = taps[i-1];
      end
      always_comb t_nxt = ~t_q;
      always_ff @(posedge ck or negedge rst_n) begin
        if (!rst_n) t_q <= 1'b0;
        else        t_q <= t_nxt;
      end
      assign taps[i] = t_q;
    end
  endgenerate
endmodule

// File: rtl/clksw_top.sv
`timescale 1ns/1ps
module clksw_top
  import clksw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int unsigned DIV_STAGES  = DIV_STAGES_DEF
) (
  input  logic clk_ref,
  input  logic clk_vco,
  input  logic rst_n,
  input  logic sel,
  output logic base_clk,
  output logic bus_clk,
  output logic busy
);
  localparam int unsigned BUS_TAP = DIV_STAGES - 1;

  src_e src;
  logic req_ref, req_vco;
  logic en_ref, en_vco;
  logic rst_ref_n, rst_vco_n;
  logic gck_ref, gck_vco;
  logic mux_clk;
  logic [DIV_STAGES-1:0] div_taps;

  assign src = src_e'(sel);

  // each leg may request only once the other leg is fully off
  assign req_ref = (src == SRC_REF) & ~en_vco;
  assign req_vco = (src == SRC_VCO) & ~en_ref;

  clksw_leg #(.STAGES(SYNC_STAGES)) u_leg_ref (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .req        (req_ref),
    .en         (en_ref),
    .rst_sync_n (rst_ref_n),
    .clk_gated  (gck_ref)
  );

  clksw_leg #(.STAGES(SYNC_STAGES)) u_leg_vco (
    .clk        (clk_vco),
    .rst_n      (rst_n),
    .req        (req_vco),
    .en         (en_vco),
    .rst_sync_n (rst_vco_n),
    .clk_gated  (gck_vco)
  );

  assign mux_clk = gck_ref | gck_vco;

  // reference domain reset: reference is the source out of reset
  clksw_div #(.STAGES(DIV_STAGES)) u_div (
    .clk_in (mux_clk),
    .rst_n  (rst_ref_n),
    .taps   (div_taps)
  );

  assign base_clk = div_taps[0];
  assign bus_clk  = div_taps[BUS_TAP];

  always_comb begin
    if (src == SRC_VCO) busy = ~en_vco | en_ref;
    else                busy = ~en_ref | en_vco;
  end

  logic unused_rst;
  assign unused_rst = rst_vco_n;
endmodule

// File: rtl/clksw_checker.sv
`timescale 1ns/1ps
module clksw_checker (
  input logic clk_ref,
  input logic clk_vco,
  input logic rst_n,
  input logic sel,
  input logic en_ref,
  input logic en_vco,
  input logic base_clk,
  input logic bus_clk,
  input logic busy
);
  // R5: never both enables on
  a_r5_one_enable: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(en_ref && en_vco)) else $error("R5 both enables active");

  a_r5_one_enable_vco: assert property (@(posedge clk_vco) disable iff (!rst_n)
    $onehot0({en_ref, en_vco})) else $error("R5 both enables active (vco)");

  // R7: a select change is followed by busy at the next reference edge
  a_r7_busy_on_change: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (sel != $past(sel)) |-> busy) else $error("R7 busy missing after select change");

  // R4: enables only move while their clock is low
  always @(en_ref) begin
    if (rst_n) a_r4_ref_low: assert (!clk_ref) else $error("R4 ref enable moved with clock high");
  end
  always @(en_vco) begin
    if (rst_n) a_r4_vco_low: assert (!clk_vco) else $error("R4 vco enable moved with clock high");
  end

  // R3: bus clock moves only at a rising base edge
  always @(bus_clk) begin
    if (rst_n) a_r3_bus_on_base: assert (base_clk) else $error("R3 bus moved without base rise");
  end
endmodule

bind clksw_top clksw_checker u_chk (
  .clk_ref  (clk_ref),
  .clk_vco  (clk_vco),
  .rst_n    (rst_n),
  .sel      (sel),
  .en_ref   (en_ref),
  .en_vco   (en_vco),
  .base_clk (base_clk),
  .bus_clk  (bus_clk),
  .busy     (busy)
);

// File: tb/clksw_top_bench.sv
`timescale 1ns/1ps
module clksw_top_bench;
  localparam real T_REF = 10.0;
  localparam real T_VCO = 7.0;
  localparam real TOL   = 0.01;

  logic clk_ref, clk_vco, rst_n, sel;
  logic base_clk, bus_clk, busy;
  logic vco_run;

  int n_checks = 0;
  int n_errs   = 0;
  int n_done   = 0;
  int glitch_errs = 0;
  bit armed = 0;
  bit finished = 0;
  real q_exp[$];
  string q_tag[$];

  clksw_top u_clksw_top (
    .clk_ref  (clk_ref),
    .clk_vco  (clk_vco),
    .rst_n    (rst_n),
    .sel      (sel),
    .base_clk (base_clk),
    .bus_clk  (bus_clk),
    .busy     (busy)
  );

  initial begin
    clk_ref = 1'b0;
    forever #5.0 clk_ref = ~clk_ref;
  end

  initial begin
    clk_vco = 1'b0;
    forever begin
      #3.5;
      if (vco_run) clk_vco = ~clk_vco;
      else         clk_vco = 1'b0;
    end
  end

  task automatic check_val(input string req, input bit ok, input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
    end
  endtask

  // R4: no base level shorter than the faster source period
  real t_last = 0.0;
  always @(base_clk) begin
    if (armed && ($realtime - t_last) < T_VCO - TOL) glitch_errs++;
    t_last = $realtime;
  end

  // monitor: pop expected source period, measure, compare
  initial begin
    forever begin
      real p, t1, t2, t3, ta, tb;
      string tag;
      wait (q_exp.size() > 0);
      p = q_exp.pop_front();
      tag = q_tag.pop_front();
      @(posedge base_clk); t1 = $realtime;
      @(negedge base_clk); t2 = $realtime;
      @(posedge base_clk); t3 = $realtime;
      check_val({"R1 base period ", tag}, ((t3 - t1) - 2.0*p) < TOL && ((t3 - t1) - 2.0*p) > -TOL, t3 - t1, 2.0*p);
      check_val({"R2 base high time ", tag}, ((t2 - t1) - p) < TOL && ((t2 - t1) - p) > -TOL, t2 - t1, p);
      @(posedge bus_clk); ta = $realtime;
      @(posedge bus_clk); tb = $realtime;
      check_val({"R3 bus period ", tag}, ((tb - ta) - 4.0*p) < TOL && ((tb - ta) - 4.0*p) > -TOL, tb - ta, 4.0*p);
      n_done++;
    end
  end

  task automatic expect_src(input real p, input string tag);
    int target;
    target = n_done + 1;
    q_exp.push_back(p);
    q_tag.push_back(tag);
    wait (n_done == target);
  endtask

  task automatic switch_to(input bit v, input string tag);
    real t0, dt;
    t0 = $realtime;
    sel = v;
    #0.5;
    check_val({"R7 busy after select ", tag}, busy == 1'b1, real'(busy), 1.0);
    wait (!busy);
    dt = $realtime - t0;
    check_val({"R6 handover time ", tag}, dt <= 3.0*T_REF + 3.0*T_VCO + TOL, dt, 3.0*T_REF + 3.0*T_VCO);
  endtask

  initial begin
    rst_n = 1'b0; sel = 1'b0; vco_run = 1'b0;
    #23.3;
    check_val("R8 reset base_clk", base_clk == 1'b0, real'(base_clk), 0.0);
    check_val("R8 reset bus_clk",  bus_clk  == 1'b0, real'(bus_clk), 0.0);
    check_val("R8 reset busy",     busy     == 1'b1, real'(busy), 1.0);
    rst_n = 1'b1;
    #100.0;
    armed = 1;
    check_val("R8 busy clear on reference, vco stopped", busy == 1'b0, real'(busy), 0.0);
    expect_src(T_REF, "ref, vco stopped (R8)");
    vco_run = 1'b1;
    #60.3;
    switch_to(1'b1, "ref->vco");
    expect_src(T_VCO, "vco");
    #31.1;
    switch_to(1'b0, "vco->ref");
    expect_src(T_REF, "ref again");
    #13.7;
    switch_to(1'b1, "ref->vco second");
    expect_src(T_VCO, "vco again");
    check_val("R4 no short base level", glitch_errs == 0, real'(glitch_errs), 0.0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #200000.0;
    if (!finished) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule